// File: doc/BRIEF.md
# Two-Lane Polyphase Half-Rate Low-Pass Filter

This block filters a real signal that was sampled very fast and arrives as two parallel lanes, each carrying every second converter sample at half the converter rate. It applies a low-pass FIR prototype that keeps the band folded down near zero frequency and removes the higher folded band. It returns one real stream at half the converter rate, so 744 Msps in gives 372 Msps out. No separate downsampler is built. The even lane feeds the sub-filter that holds the even-indexed coefficients. The odd lane, delayed by one output sample, feeds the sub-filter that holds the odd-indexed coefficients. The two partial sums are added, rounded and saturated. Every multiply and add therefore runs at the output rate.

The stream has only a valid strobe and no back-pressure. A sample pair is accepted on each clock edge where `in_valid` is high. The delay lines stay frozen while `in_valid` is low. `out_valid` repeats the input strobe after a fixed pipeline latency. Coefficients, widths, tap count and output scaling are parameters.

Top module: `lane_pair_decim2`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `out_valid` is 0 and `out_sample` is 0. Synchronous reset clears both delay lines, the one-sample lane delay and all pipeline registers.
- R2: `out_valid` is high in a clock cycle exactly when `in_valid` was high four cycles earlier, that is, when `in_valid` was sampled at the edge three edges before the edge that raised `out_valid`. It is 0 for the first four cycles after reset.
- R3: Number the accepted pairs m = 0, 1, 2, … since reset, with a[m] on `lane_a` (even converter sample) and b[m] on `lane_b` (odd converter sample), and let the coefficient k be the signed CW-bit field COEFS[k*CW +: CW]. Output number m is then the full-precision sum of h[2j]·a[m−j] + h[2j+1]·b[m−j−1] over j = 0 … NTAPS/2−1, where samples with a negative index count as 0. It is presented on the m-th cycle in which `out_valid` is high.
- R4: The odd lane reaches its sub-filter one accepted pair late. A lone nonzero value on `lane_b` at pair m first affects output m+1 and never output m.
- R5: The full-precision sum s is scaled to s' = floor((s + 2^(SHIFT−1)) / 2^SHIFT). This is round half up, done with an arithmetic right shift of SHIFT bits (default 4).
- R6: If s' is above 2^(OW−1)−1, the output is 2^(OW−1)−1 (32767 by default). If s' is below −2^(OW−1), the output is −2^(OW−1) (−32768).
- R7: Lane values present on a cycle with `in_valid` low are ignored. The delay lines do not move, and later outputs are the same as if that cycle had not occurred.
- R8: A reset in the middle of a stream drops all earlier history. The first outputs after reset are computed as if every earlier sample were 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Lane pair present this cycle |
| lane_a | input | DW | Even-indexed converter sample, signed |
| lane_b | input | DW | Odd-indexed converter sample, signed |
| out_valid | output | 1 | Filtered sample present this cycle |
| out_sample | output | OW | Rounded, saturated filter output, signed |

## Verification
Two functions can fall in the same cycle: a gap in `in_valid` freezes the delay lines while samples accepted earlier are still moving through the product and sum registers toward the output. The bench provokes this with a repeating two-on, one-off valid pattern and puts unrelated values on both lanes during every gap. It judges the result by checking that `out_valid` reproduces the gap pattern four cycles later. It also checks that every valid output equals the arithmetic model, which is indexed only by accepted pairs, so a gap that leaks into the history or stalls the drain shows up as a wrong value or a misplaced strobe.

// File: rtl/ldec_pkg.sv
package ldec_pkg;

  // Bits needed to hold the sum of `terms` signed products of dw x cw bits,
  // with one guard bit.
  function automatic int sum_width(input int dw, input int cw, input int terms);
    int n;
    n = 0;
    while ((1 << n) < terms) n++;
    return dw + cw + n + 1;
  endfunction

  // Rounding bias added before a right shift by `shift` bits.
  function automatic longint round_bias(input int shift);
    return (shift > 0) ? (longint'(1) <<< (shift - 1)) : longint'(0);
  endfunction

endpackage

// File: rtl/ldec_tapline.sv
// Shift register of signed samples. Tap 0 is the newest.
module ldec_tapline #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [W-1:0]         din,
  output logic [DEPTH*W-1:0]   taps
);

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)     taps <= '0;
        else if (en) taps <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst)     taps <= '0;
        else if (en) taps <= {taps[(DEPTH-1)*W-1:0], din};
      end
    end
  endgenerate

endmodule

// File: rtl/ldec_subfilter.sv
// One polyphase branch: registered products, then a registered adder tree.
module ldec_subfilter #(
  parameter int              DW    = 8,
  parameter int              CW    = 12,
  parameter int              T     = 8,
  parameter int              SW    = 24,
  parameter logic [T*CW-1:0] COEFS = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [T*DW-1:0]      taps,
  output logic signed [SW-1:0] sum
);

  localparam int PW = DW + CW;

  logic signed [PW-1:0] prod_q [T];
  logic signed [SW-1:0] sum_d;

  function automatic logic signed [CW-1:0] coef(input int j);
    return COEFS[j*CW +: CW];
  endfunction

  function automatic logic signed [DW-1:0] tap(input logic [T*DW-1:0] v, input int j);
    return v[j*DW +: DW];
  endfunction

  always_ff @(posedge clk) begin
    for (int j = 0; j < T; j++) begin
      if (rst) prod_q[j] <= '0;
      else     prod_q[j] <= PW'(tap(taps, j)) * PW'(coef(j));
    end
  end

  always_comb begin
    sum_d = '0;
    for (int j = 0; j < T; j++) sum_d = sum_d + SW'(prod_q[j]);
  end

  always_ff @(posedge clk) begin
    if (rst) sum <= '0;
    else     sum <= sum_d;
  end

endmodule

// File: rtl/ldec_round_sat.sv
// Round half up by an arithmetic shift, clamp to OW bits, register.
module ldec_round_sat #(
  parameter int AW    = 26,
  parameter int OW    = 16,
  parameter int SHIFT = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [AW-1:0] acc,
  output logic signed [OW-1:0] q
);

  localparam logic signed [AW:0] MAXV = (AW+1)'((longint'(1) <<< (OW-1)) - 1);
  localparam logic signed [AW:0] MINV = (AW+1)'(-(longint'(1) <<< (OW-1)));

  logic signed [AW:0]   scaled;
  logic signed [OW-1:0] q_d;

  generate
    if (SHIFT == 0) begin : g_noshift
      assign scaled = (AW+1)'(acc);
    end else begin : g_shift
      localparam logic signed [AW:0] BIAS = (AW+1)'(ldec_pkg::round_bias(SHIFT));
      logic signed [AW:0] biased;
      assign biased = (AW+1)'(acc) + BIAS;
      assign scaled = biased >>> SHIFT;
    end
  endgenerate

  always_comb begin
    if (scaled > MAXV)      q_d = MAXV[OW-1:0];
    else if (scaled < MINV) q_d = MINV[OW-1:0];
    else                    q_d = scaled[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_d;
  end

endmodule

// File: rtl/lane_pair_decim2.sv
// Two-lane polyphase half-rate low-pass filter.
// NTAPS must be even; coefficient k sits in COEFS[k*CW +: CW].
module lane_pair_decim2 #(
  parameter int                  DW    = 8,
  parameter int                  CW    = 12,
  parameter int                  NTAPS = 16,
  parameter int                  OW    = 16,
  parameter int                  SHIFT = 4,
  parameter logic [NTAPS*CW-1:0] COEFS = {
    12'hFF8, 12'hFEC, 12'hFF0, 12'd40, 12'd130, 12'd260, 12'd390, 12'd470,
    12'd470, 12'd390, 12'd260, 12'd130, 12'd40, 12'hFF0, 12'hFEC, 12'hFF8}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [DW-1:0]        lane_a,
  input  logic [DW-1:0]        lane_b,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_sample
);

  localparam int T     = NTAPS / 2;
  localparam int SW    = ldec_pkg::sum_width(DW, CW, T);
  localparam int AW    = SW + 1;
  localparam int STAGES = 4;   // tap load, products, branch sums, round

  function automatic logic [T*CW-1:0] phase_coefs(input int ph);
    logic [T*CW-1:0] r;
    r = '0;
    for (int j = 0; j < T; j++) r[j*CW +: CW] = COEFS[(2*j+ph)*CW +: CW];
    return r;
  endfunction

  localparam logic [T*CW-1:0] C_EVEN = phase_coefs(0);
  localparam logic [T*CW-1:0] C_ODD  = phase_coefs(1);

  logic [T*DW-1:0]      a_taps;
  logic [T*DW-1:0]      b_taps;
  logic [DW-1:0]        b_late;
  logic signed [SW-1:0] sum_even;
  logic signed [SW-1:0] sum_odd;
  logic signed [AW-1:0] acc_full;
  logic [STAGES-1:0]    vpipe;

  // Odd lane held back one accepted pair to align its phase.
  always_ff @(posedge clk) begin
    if (rst)           b_late <= '0;
    else if (in_valid) b_late <= lane_b;
  end

  ldec_tapline #(.W(DW), .DEPTH(T)) u_line_even (
    .clk(clk), .rst(rst), .en(in_valid), .din(lane_a), .taps(a_taps));

  ldec_tapline #(.W(DW), .DEPTH(T)) u_line_odd (
    .clk(clk), .rst(rst), .en(in_valid), .din(b_late), .taps(b_taps));

  ldec_subfilter #(.DW(DW), .CW(CW), .T(T), .SW(SW), .COEFS(C_EVEN)) u_sub_even (
    .clk(clk), .rst(rst), .taps(a_taps), .sum(sum_even));

  ldec_subfilter #(.DW(DW), .CW(CW), .T(T), .SW(SW), .COEFS(C_ODD)) u_sub_odd (
    .clk(clk), .rst(rst), .taps(b_taps), .sum(sum_odd));

  assign acc_full = AW'(sum_even) + AW'(sum_odd);

  ldec_round_sat #(.AW(AW), .OW(OW), .SHIFT(SHIFT)) u_round (
    .clk(clk), .rst(rst), .acc(acc_full), .q(out_sample));

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[STAGES-2:0], in_valid};
  end

  assign out_valid = vpipe[STAGES-1];

endmodule

// File: rtl/ldec_checker.sv
module ldec_checker #(
  parameter int AW    = 26,
  parameter int OW    = 16,
  parameter int SHIFT = 4,
  parameter int LW    = 64
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_sample,
  input logic signed [AW-1:0] acc_full,
  input logic [LW-1:0]        a_taps
);

  localparam longint LIMIT  = longint'(1) <<< (OW - 1 + SHIFT);
  localparam longint HALF   = ldec_pkg::round_bias(SHIFT);
  localparam longint POS_AT = LIMIT - HALF;
  localparam longint NEG_AT = -LIMIT - HALF;
  localparam logic signed [OW-1:0] TOP = OW'((longint'(1) <<< (OW-1)) - 1);
  localparam logic signed [OW-1:0] BOT = OW'(-(longint'(1) <<< (OW-1)));

  logic [3:0] seen_valid;
  always_ff @(posedge clk) begin
    if (rst) seen_valid <= '0;
    else     seen_valid <= {seen_valid[2:0], in_valid};
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && out_sample == '0)); // R1

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    out_valid == seen_valid[3]); // R2

  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (longint'(acc_full) >= POS_AT) |=> out_sample == TOP); // R6

  AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
    (longint'(acc_full) < NEG_AT) |=> out_sample == BOT); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(a_taps)); // R7

endmodule

bind lane_pair_decim2 ldec_checker #(.AW(AW), .OW(OW), .SHIFT(SHIFT), .LW(T*DW)) u_ldec_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .out_sample(out_sample), .acc_full(acc_full), .a_taps(a_taps));

// File: tb/lane_pair_decim2_test.sv
`timescale 1ns/1ps
module lane_pair_decim2_test;

  localparam int DW = 8, CW = 12, NT = 16, OW = 16, SH = 4;
  localparam int HALFT = NT / 2;

  function automatic int h(input int k);
    return ((k % 2) ? -1 : 1) * (k + 1) * 37;
  endfunction

  function automatic logic [NT*CW-1:0] mk_coefs();
    logic [NT*CW-1:0] r;
    for (int k = 0; k < NT; k++) r[k*CW +: CW] = CW'(h(k));
    return r;
  endfunction

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [DW-1:0] lane_a = '0;
  logic [DW-1:0] lane_b = '0;
  logic out_valid;
  logic signed [OW-1:0] out_sample;

  always #10 clk = ~clk;

  lane_pair_decim2 #(.DW(DW), .CW(CW), .NTAPS(NT), .OW(OW), .SHIFT(SH),
                     .COEFS(mk_coefs())) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .lane_a(lane_a), .lane_b(lane_b),
    .out_valid(out_valid), .out_sample(out_sample));

  int checks = 0, errors = 0;
  int a_h [0:8191];
  int b_h [0:8191];
  bit vlog [0:8191];
  int ns = 0, no = 0, cyc = 0;

  function automatic int model_y(input int m);
    longint acc, r;
    acc = 0;
    for (int j = 0; j < HALFT; j++) begin
      if (m - j >= 0)     acc += longint'(h(2*j)) * a_h[m-j];
      if (m - j - 1 >= 0) acc += longint'(h(2*j+1)) * b_h[m-j-1];
    end
    r = (acc + 8) >>> SH;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic step(input int a, input int b, input bit v, input string tag);
    bit ev;
    int ey;
    @(negedge clk);
    ev = (cyc >= 4) ? vlog[cyc-4] : 1'b0;
    checks++;
    if (out_valid !== ev) begin
      errors++;
      $display("FAIL R2: out_valid=%0b expected %0b (cycle %0d)", out_valid, ev, cyc);
    end
    if (out_valid === 1'b1 && ev) begin
      ey = model_y(no);
      checks++;
      if (int'(out_sample) != ey) begin
        errors++;
        $display("FAIL %s: out_sample=%0d expected %0d (output %0d)", tag, out_sample, ey, no);
      end
      no++;
    end
    in_valid = v;
    lane_a = DW'(a);
    lane_b = DW'(b);
    if (v) begin
      a_h[ns] = a;
      b_h[ns] = b;
      ns++;
    end
    vlog[cyc] = v;
    cyc++;
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < 6; i++) step(0, 0, 1'b0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_sample !== '0) begin
      errors++;
      $display("FAIL R1: out_valid=%0b out_sample=%0d expected 0 and 0", out_valid, out_sample);
    end
    rst = 1'b0;
    vlog[0] = 1'b0;
    cyc = 1;
    ns = 0;
    no = 0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run still busy, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] lf;
    do_reset();                                   // R1

    // R3: lane A impulse reproduces the even coefficients
    step(64, 0, 1'b1, "R3");
    for (int i = 0; i < 10; i++) step(0, 0, 1'b1, "R3");
    flush("R3");

    // R4: lane B impulse lands one pair late on the odd coefficients
    do_reset();
    step(0, 64, 1'b1, "R4");
    for (int i = 0; i < 10; i++) step(0, 0, 1'b1, "R4");
    flush("R4");

    // R3: exhaustive sweep of lane A with a scrambled lane B
    do_reset();
    for (int i = -128; i < 128; i++) step(i, ((i * 53 + 7) & 255) - 128, 1'b1, "R3");
    flush("R3");
    // and of lane B
    do_reset();
    for (int i = -128; i < 128; i++) step(((i * 91 + 3) & 255) - 128, i, 1'b1, "R3");
    flush("R3");

    // R5: small values so that rounding fractions dominate
    do_reset();
    lf = 8'h5A;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      step(int'(lf[2:0]) - 3, int'(lf[6:4]) - 4, 1'b1, "R5");
    end
    flush("R5");

    // R6: drive both saturation limits
    do_reset();
    for (int i = 0; i < 20; i++) step(127, -128, 1'b1, "R6");
    for (int i = 0; i < 20; i++) step(-128, 127, 1'b1, "R6");
    flush("R6");

    // R7: gaps with junk on the lanes during idle cycles
    do_reset();
    for (int i = 0; i < 300; i++) begin
      if (i % 3 == 2) step(((i * 29) & 255) - 128, -((i * 13) & 127), 1'b0, "R7");
      else            step(((i * 71 + 5) & 255) - 128, ((i * 17 + 9) & 255) - 128, 1'b1, "R7");
    end
    flush("R7");

    // R8: reset in mid-stream, then an impulse on fresh history
    do_reset();
    for (int i = 0; i < 20; i++) step(100 - i, -90 + i, 1'b1, "R8");
    do_reset();
    step(32, -32, 1'b1, "R8");
    for (int i = 0; i < 12; i++) step(0, 0, 1'b1, "R8");
    flush("R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule